// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block turns single host requests into strobe sequences on an asynchronous NAND flash bus. A request names a direction, one of three address windows (command, address or data), a timing space (common or attribute) and up to 16 bits of write data. The window decides which latch-enable line stays high for the whole access. Command accesses raise the command latch enable, address accesses raise the address latch enable, and data accesses raise neither. Every access then runs through four phases: setup, strobe, hold and bus release. Each phase length comes from a byte of the selected timing word.

The host programs one control word and two timing words through a small configuration write port. The control word carries the following fields:
- a soft-reset bit
- a wait-on-ready enable
- a bank enable and a NAND device-type bit, which must both be set before requests are accepted
- the device width (8-bit or 16-bit)
- two 4-bit delays that stretch the gap before the read strobe when a read follows a command or an address access

Read data is captured as the read strobe ends and is returned with a one-cycle valid pulse.

Top module: `nfc_bus_seq`

## Requirements
- R1: After reset the chip enable, write strobe and read strobe are high and the data bus is not driven. Both timing words hold 0x0104_0600 (setup 0, strobe 6, hold 4, release 1). The control word holds 0x0000_000C (enabled, NAND type, 8-bit, wait-on-ready off, delays 0).
- R2: Window code 1 selects the command window and keeps nand_cle high for the whole access. Code 2 selects the address window and keeps nand_ale high. Codes 0 and 3 are data accesses, during which both lines stay low.
- R3: A timing word holds the setup count in bits [7:0], the strobe count in [15:8], the hold count in [23:16] and the release count in [31:24]. An access keeps nand_ce_n low for the sum of the four counts. The strobe (nand_we_n for writes, nand_re_n for reads) goes low after the setup count and stays low for the strobe count.
- R4: A count of zero in any of the four phase fields lasts one cycle.
- R5: A request with req_attr = 1 uses the attribute timing word (configuration address 2). A request with req_attr = 0 uses the common timing word (configuration address 1). The control word is at configuration address 0.
- R6: The read strobe is delayed by extra cycles that depend on the previous access:
  - after a command-window access, by the value of control bits [12:9];
  - after an address-window access, by the value of control bits [16:13];
  - after a data access, by nothing.
- R7: A write drives nand_dq_oe for every cycle that nand_ce_n is low, including the release phase. A read never drives it.
- R8: Control bit 4 selects 16-bit width. In 8-bit mode, bits [15:8] of nand_dq_out and of rsp_rdata are zero.
- R9: A read samples nand_dq_in on its last strobe cycle and presents it on rsp_rdata with rsp_valid high for exactly one cycle.
- R10: When control bit 1 is set, a read strobe stays low past its count while nand_rb is low. When the bit is clear, nand_rb has no effect.
- R11: req_ready is high only while no access is in progress and the control word has bit 2 and bit 3 set and bit 0 clear. Otherwise a valid request is not started.
- R12: The write and read strobes are never low together, and neither is low while nand_ce_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration select: 0 control, 1 common timing, 2 attribute timing |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 2 | Window: 0 data, 1 command, 2 address |
| req_attr | input | 1 | Timing space select |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 16 | Data bus input value |
| nand_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
The stretched read-strobe gap can only be seen if a read follows a particular earlier access. The bench therefore runs fixed pairs: a command write then a data read, a data read then another data read, and an address write then a data read. In each pair it measures how many cycles separate the fall of chip enable from the fall of the read strobe. The ready/busy stall is reached by holding nand_rb low before a read starts and raising it part way through the strobe. Both settings of the wait enable are compared for the same read.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  localparam int TF_W  = 8;   // width of one phase count
  localparam int DLY_W = 4;   // width of a latch-to-read delay

  typedef enum logic [1:0] {
    WIN_DATA = 2'd0,
    WIN_CMD  = 2'd1,
    WIN_ADDR = 2'd2,
    WIN_ALT  = 2'd3
  } win_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_RELEASE
  } phase_e;

  // bit 31 .. bit 0 : release, hold, strobe, setup
  typedef struct packed {
    logic [TF_W-1:0] release_cnt;
    logic [TF_W-1:0] hold_cnt;
    logic [TF_W-1:0] strobe_cnt;
    logic [TF_W-1:0] setup_cnt;
  } timing_t;

  typedef struct packed {
    logic [DLY_W-1:0] ale_re;
    logic [DLY_W-1:0] cle_re;
    logic             wide;
    logic             nand_type;
    logic             enable;
    logic             rdy_wait;
    logic             soft_rst;
  } ctrl_t;

endpackage

// File: rtl/nfc_cfg_regs.sv
module nfc_cfg_regs
  import nfc_pkg::*;
#(
  parameter int      NUM_SPACES = 2,
  parameter int      CA_W       = 2,
  parameter logic [31:0] TIM_RST  = 32'h0104_0600,
  parameter logic [31:0] CTRL_RST = 32'h0000_000C
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [CA_W-1:0]              cfg_addr,
  input  logic [$bits(timing_t)-1:0]   cfg_wdata,
  output ctrl_t                        ctrl,
  output timing_t [NUM_SPACES-1:0]     tim_set
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  ctrl_hit;

  assign ctrl_hit = cfg_we && (cfg_addr == '0);

  always_comb begin
    ctrl_d.soft_rst  = cfg_wdata[0];
    ctrl_d.rdy_wait  = cfg_wdata[1];
    ctrl_d.enable    = cfg_wdata[2];
    ctrl_d.nand_type = cfg_wdata[3];
    ctrl_d.wide      = cfg_wdata[4];
    ctrl_d.cle_re    = cfg_wdata[9 +: DLY_W];
    ctrl_d.ale_re    = cfg_wdata[13 +: DLY_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.soft_rst  <= CTRL_RST[0];
      ctrl_q.rdy_wait  <= CTRL_RST[1];
      ctrl_q.enable    <= CTRL_RST[2];
      ctrl_q.nand_type <= CTRL_RST[3];
      ctrl_q.wide      <= CTRL_RST[4];
      ctrl_q.cle_re    <= CTRL_RST[9 +: DLY_W];
      ctrl_q.ale_re    <= CTRL_RST[13 +: DLY_W];
    end else if (ctrl_hit) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl = ctrl_q;

  for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
    timing_t tim_q;
    logic    hit;

    assign hit = cfg_we && (cfg_addr == CA_W'(s + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tim_q <= timing_t'(TIM_RST);
      end else if (hit) begin
        tim_q <= timing_t'(cfg_wdata);
      end
    end

    assign tim_set[s] = tim_q;
  end

endmodule

// File: rtl/nfc_phase_timer.sv
module nfc_phase_timer #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  output logic             done
);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_d;
  logic             cnt_en;

  // len is never zero: the sequencer folds zero counts to one
  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) begin
      cnt_d = len - LEN_W'(1);
    end else begin
      cnt_d = cnt_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int DW         = 16,
  parameter int NUM_SPACES = 2,
  parameter int RB_SYNC    = 2,
  parameter int LEN_W      = TF_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrl_t                    ctrl,
  input  timing_t [NUM_SPACES-1:0] tim_set,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [1:0]               req_win,
  input  logic                     req_attr,
  input  logic [DW-1:0]            req_wdata,
  output logic                     rsp_valid,
  output logic [DW-1:0]            rsp_rdata,
  output logic                     timer_load,
  output logic [LEN_W-1:0]         timer_len,
  input  logic                     timer_done,
  output logic                     nand_ce_n,
  output logic                     nand_cle,
  output logic                     nand_ale,
  output logic                     nand_we_n,
  output logic                     nand_re_n,
  output logic [DW-1:0]            nand_dq_out,
  output logic                     nand_dq_oe,
  input  logic [DW-1:0]            nand_dq_in,
  input  logic                     nand_rb
);

  localparam int HW = DW / 2;

  phase_e              ph_q, ph_d;
  logic                wr_q;
  win_e                win_q;
  win_e                last_q, last_d;
  logic                attr_q;
  logic [DW-1:0]       wdata_q;
  logic                rsp_q, rsp_d;
  logic [DW-1:0]       rdata_q, rdata_cap;
  logic [RB_SYNC-1:0]  rb_sync_q;
  logic                rb_s;
  logic                accept;
  logic                stall;
  logic                active;
  timing_t             tim_req, tim_cur;
  logic [LEN_W-1:0]    ext;

  function automatic logic [LEN_W-1:0] eff(input logic [TF_W-1:0] v);
    return (v == '0) ? LEN_W'(1) : LEN_W'(v);
  endfunction

  assign rb_s      = rb_sync_q[RB_SYNC-1];
  assign req_ready = (ph_q == PH_IDLE) && ctrl.enable && ctrl.nand_type && !ctrl.soft_rst;
  assign accept    = req_valid && req_ready;
  assign tim_req   = tim_set[req_attr];
  assign tim_cur   = tim_set[attr_q];
  assign stall     = !wr_q && ctrl.rdy_wait && !rb_s;
  assign rdata_cap = ctrl.wide ? nand_dq_in : {{(DW-HW){1'b0}}, nand_dq_in[HW-1:0]};

  always_comb begin
    case (last_q)
      WIN_CMD:  ext = LEN_W'(ctrl.cle_re);
      WIN_ADDR: ext = LEN_W'(ctrl.ale_re);
      default:  ext = '0;
    endcase
  end

  // next-state logic
  always_comb begin
    ph_d       = ph_q;
    last_d     = last_q;
    rsp_d      = 1'b0;
    timer_load = 1'b0;
    timer_len  = LEN_W'(1);
    case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          ph_d       = PH_SETUP;
          timer_load = 1'b1;
          timer_len  = eff(tim_req.setup_cnt) + (req_write ? '0 : ext);
        end
      end
      PH_SETUP: begin
        if (timer_done) begin
          ph_d       = PH_STROBE;
          timer_load = 1'b1;
          timer_len  = eff(tim_cur.strobe_cnt);
        end
      end
      PH_STROBE: begin
        if (timer_done && !stall) begin
          ph_d       = PH_HOLD;
          timer_load = 1'b1;
          timer_len  = eff(tim_cur.hold_cnt);
          rsp_d      = !wr_q;
        end
      end
      PH_HOLD: begin
        if (timer_done) begin
          ph_d       = PH_RELEASE;
          timer_load = 1'b1;
          timer_len  = eff(tim_cur.release_cnt);
        end
      end
      PH_RELEASE: begin
        if (timer_done) begin
          ph_d   = PH_IDLE;
          last_d = win_q;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
    if (ctrl.soft_rst) begin
      ph_d       = PH_IDLE;
      timer_load = 1'b0;
      rsp_d      = 1'b0;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      last_q    <= WIN_DATA;
      rsp_q     <= 1'b0;
      wr_q      <= 1'b0;
      win_q     <= WIN_DATA;
      attr_q    <= 1'b0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      rb_sync_q <= '0;
    end else begin
      ph_q      <= ph_d;
      last_q    <= last_d;
      rsp_q     <= rsp_d;
      rb_sync_q <= {rb_sync_q[RB_SYNC-2:0], nand_rb};
      if (accept) begin
        wr_q    <= req_write;
        win_q   <= win_e'(req_win);
        attr_q  <= req_attr;
        wdata_q <= req_wdata;
      end
      if (rsp_d) begin
        rdata_q <= rdata_cap;
      end
    end
  end

  // bus decode from state
  assign active      = (ph_q != PH_IDLE);
  assign nand_ce_n   = !active;
  assign nand_cle    = active && (win_q == WIN_CMD);
  assign nand_ale    = active && (win_q == WIN_ADDR);
  assign nand_we_n   = !((ph_q == PH_STROBE) && wr_q);
  assign nand_re_n   = !((ph_q == PH_STROBE) && !wr_q);
  assign nand_dq_oe  = active && wr_q;
  assign nand_dq_out = ctrl.wide ? wdata_q : {{(DW-HW){1'b0}}, wdata_q[HW-1:0]};
  assign rsp_valid   = rsp_q;
  assign rsp_rdata   = rdata_q;

endmodule

// File: rtl/nfc_bus_seq.sv
module nfc_bus_seq
  import nfc_pkg::*;
#(
  parameter int DW         = 16,
  parameter int NUM_SPACES = 2,
  parameter int CA_W       = 2,
  parameter int RB_SYNC    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_win,
  input  logic          req_attr,
  input  logic [15:0]   req_wdata,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [15:0]   nand_dq_out,
  output logic          nand_dq_oe,
  input  logic [15:0]   nand_dq_in,
  input  logic          nand_rb
);

  localparam int LEN_W = TF_W + 1;

  logic [1:0]               rst_sync_q;
  logic                     rst_int_n;
  ctrl_t                    ctrl;
  timing_t [NUM_SPACES-1:0] tim_set;
  logic                     timer_load;
  logic [LEN_W-1:0]         timer_len;
  logic                     timer_done;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  nfc_cfg_regs #(
    .NUM_SPACES (NUM_SPACES),
    .CA_W       (CA_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ctrl      (ctrl),
    .tim_set   (tim_set)
  );

  nfc_phase_timer #(
    .LEN_W (LEN_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (timer_load),
    .len   (timer_len),
    .done  (timer_done)
  );

  nfc_seq #(
    .DW         (DW),
    .NUM_SPACES (NUM_SPACES),
    .RB_SYNC    (RB_SYNC),
    .LEN_W      (LEN_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ctrl        (ctrl),
    .tim_set     (tim_set),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_win     (req_win),
    .req_attr    (req_attr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .timer_load  (timer_load),
    .timer_len   (timer_len),
    .timer_done  (timer_done),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_dq_out (nand_dq_out),
    .nand_dq_oe  (nand_dq_oe),
    .nand_dq_in  (nand_dq_in),
    .nand_rb     (nand_rb)
  );

endmodule

// File: rtl/nfc_bus_seq_chk.sv
module nfc_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_dq_oe
);

  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  a_r12_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  a_r2_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> nand_ce_n);

  a_r7_no_drive_read: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  a_r7_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_dq_oe) |-> $rose(nand_ce_n));

  a_r3_setup_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_ce_n) |-> (nand_we_n && nand_re_n));

endmodule

bind nfc_bus_seq nfc_bus_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .nand_ce_n  (nand_ce_n),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_oe (nand_dq_oe)
);

// File: tb/tb_nfc_bus_seq.sv
`timescale 1ns/1ps
module tb_nfc_bus_seq;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [1:0]  req_win;
  logic        req_attr;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [15:0] nand_dq_out;
  logic [15:0] nand_dq_in;
  logic        nand_rb;

  int n_total = 0;
  int n_fail  = 0;

  // per-access measurements
  int m_ce, m_we, m_re, m_oe, m_cle, m_ale, m_we_start, m_re_start, m_rsp, m_bad;
  logic [15:0] m_rdata, m_dq;

  nfc_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_win(req_win),
    .req_attr(req_attr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic chk_range(input string tag, input int act, input int lo, input int hi);
    n_total++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_access(input logic wr, input logic [1:0] win, input logic attr,
                            input logic [15:0] wd, input int rb_rel);
    int idx;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_win = win; req_attr = attr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    m_ce = 0; m_we = 0; m_re = 0; m_oe = 0; m_cle = 0; m_ale = 0;
    m_we_start = -1; m_re_start = -1; m_rsp = 0; m_bad = 0; m_rdata = '0; m_dq = '0;
    idx = 0;
    while (!nand_ce_n && idx < 3000) begin
      m_ce++;
      if (!nand_we_n) begin
        if (m_we_start < 0) m_we_start = idx;
        m_we++; m_dq = nand_dq_out;
      end
      if (!nand_re_n) begin
        if (m_re_start < 0) m_re_start = idx;
        m_re++;
      end
      if (!nand_we_n && !nand_re_n) m_bad++;
      if (nand_dq_oe) m_oe++;
      if (nand_cle) m_cle++;
      if (nand_ale) m_ale++;
      if (rsp_valid) begin m_rsp++; m_rdata = rsp_rdata; end
      idx++;
      if (idx == rb_rel) nand_rb = 1'b1;
      @(negedge clk);
    end
    if (rsp_valid) m_rsp++;
  endtask

  task automatic t_reset;
    chk("R1 ce_n idle", nand_ce_n, 1);
    chk("R1 we_n idle", nand_we_n, 1);
    chk("R1 re_n idle", nand_re_n, 1);
    chk("R1 dq_oe idle", nand_dq_oe, 0);
    chk("R11 ready after reset", req_ready, 1);
  endtask

  task automatic t_default_write;
    run_access(1'b1, 2'd1, 1'b0, 16'hA55A, -1);
    chk("R1 default ce span", m_ce, 12);
    chk("R1 default strobe", m_we, 6);
    chk("R3 strobe start", m_we_start, 1);
    chk("R2 cle on cmd", m_cle, 12);
    chk("R2 ale off on cmd", m_ale, 0);
    chk("R7 oe on write", m_oe, 12);
    chk("R8 8-bit write data", m_dq, 16'h005A);
    chk("R12 no overlap", m_bad, 0);
    chk("R12 no re on write", m_re, 0);
  endtask

  task automatic t_program;
    cfg_write(2'd1, 32'h0203_0504);
    run_access(1'b1, 2'd2, 1'b0, 16'h0011, -1);
    chk("R3 ce span", m_ce, 14);
    chk("R3 strobe len", m_we, 5);
    chk("R3 strobe start", m_we_start, 4);
    chk("R2 ale on addr", m_ale, 14);
    chk("R2 cle off on addr", m_cle, 0);
  endtask

  task automatic t_zero;
    cfg_write(2'd1, 32'h0000_0000);
    run_access(1'b1, 2'd0, 1'b0, 16'h0022, -1);
    chk("R4 zero counts span", m_ce, 4);
    chk("R4 zero strobe", m_we, 1);
    chk("R2 data window no latch", m_cle + m_ale, 0);
    run_access(1'b1, 2'd3, 1'b0, 16'h0033, -1);
    chk("R2 code 3 no latch", m_cle + m_ale, 0);
  endtask

  task automatic t_attr;
    cfg_write(2'd1, 32'h0101_0201);
    cfg_write(2'd2, 32'h0101_0801);
    run_access(1'b1, 2'd0, 1'b1, 16'h0044, -1);
    chk("R5 attribute strobe", m_we, 8);
    run_access(1'b1, 2'd0, 1'b0, 16'h0055, -1);
    chk("R5 common strobe", m_we, 2);
  endtask

  task automatic t_read_delay;
    cfg_write(2'd0, 32'h0000_A60C);
    cfg_write(2'd1, 32'h0101_0302);
    run_access(1'b1, 2'd1, 1'b0, 16'h0070, -1);
    run_access(1'b0, 2'd0, 1'b0, 16'h0000, -1);
    chk("R6 read after cmd", m_re_start, 5);
    chk("R3 read strobe len", m_re, 3);
    chk("R7 no oe on read", m_oe, 0);
    run_access(1'b0, 2'd0, 1'b0, 16'h0000, -1);
    chk("R6 read after data", m_re_start, 2);
    run_access(1'b1, 2'd2, 1'b0, 16'h0001, -1);
    run_access(1'b0, 2'd0, 1'b0, 16'h0000, -1);
    chk("R6 read after addr", m_re_start, 7);
    cfg_write(2'd0, 32'h0000_000C);
  endtask

  task automatic t_width;
    nand_dq_in = 16'hBEEF;
    run_access(1'b0, 2'd0, 1'b0, 16'h0000, -1);
    chk("R9 one rsp pulse", m_rsp, 1);
    chk("R8 8-bit read data", m_rdata, 16'h00EF);
    cfg_write(2'd0, 32'h0000_001C);
    run_access(1'b0, 2'd0, 1'b0, 16'h0000, -1);
    chk("R9 16-bit read data", m_rdata, 16'hBEEF);
    run_access(1'b1, 2'd0, 1'b0, 16'h1234, -1);
    chk("R8 16-bit write data", m_dq, 16'h1234);
    cfg_write(2'd0, 32'h0000_000C);
  endtask

  task automatic t_ready_wait;
    cfg_write(2'd1, 32'h0101_0301);
    cfg_write(2'd0, 32'h0000_000E);
    nand_rb = 1'b0;
    repeat (4) @(negedge clk);
    run_access(1'b0, 2'd0, 1'b0, 16'h0000, 10);
    chk_range("R10 stalled strobe", m_re, 10, 14);
    chk("R10 rsp after stall", m_rsp, 1);
    cfg_write(2'd0, 32'h0000_000C);
    nand_rb = 1'b0;
    repeat (4) @(negedge clk);
    run_access(1'b0, 2'd0, 1'b0, 16'h0000, -1);
    chk("R10 rb ignored when off", m_re, 3);
    nand_rb = 1'b1;
  endtask

  task automatic t_gate(input logic [31:0] cw, input string tag);
    int lows;
    cfg_write(2'd0, cw);
    @(negedge clk);
    chk({tag, " ready low"}, req_ready, 0);
    req_valid = 1'b1; req_write = 1'b1; req_win = 2'd0;
    lows = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!nand_ce_n) lows++;
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk({tag, " no access started"}, lows, 0);
    cfg_write(2'd0, 32'h0000_000C);
    @(negedge clk);
    chk({tag, " ready back"}, req_ready, 1);
  endtask

  initial begin
    #2_000_000;
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_win = '0; req_attr = 1'b0; req_wdata = '0;
    nand_dq_in = '0; nand_rb = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_default_write();
    t_program();
    t_zero();
    t_attr();
    t_read_delay();
    t_width();
    t_ready_wait();
    t_gate(32'h0000_000D, "R11 soft reset");
    t_gate(32'h0000_0008, "R11 bank disabled");
    t_gate(32'h0000_0004, "R11 not nand type");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule